// File: doc/BRIEF.md
# Phase-Accumulator Serial Transmitter

This block sends bytes over an asynchronous serial line, one direction only. The bit rate does not come from an integer clock divider. A wide phase accumulator adds a programmable increment on every system clock. Each rising edge of its top bit gives a one-cycle baud tick. Because the increment is a runtime input, any bit rate up to half the clock rate can be reached, with a fractional average period and no change to the logic.

A byte enters through a valid/ready handshake and waits in a one-entry holding register. On the next baud tick it is framed as follows: a low start bit, eight data bits sent least significant bit first, and two high stop bits. The frame is then shifted out one bit per tick. Between frames the line rests high. A byte offered while the second stop bit is on the line is taken at once and follows that stop bit with no gap.

Top module: `uart_tx_phase`

## Requirements
- R1: On every clock the 20-bit accumulator adds `inc_i`, modulo 2^20. A baud tick happens in each cycle where the accumulator's top bit is 1 and was 0 one cycle earlier. Each bit therefore lasts 2^20/`inc_i` clocks on average, and exactly 16 clocks when `inc_i` = 65536.
- R2: Each frame is 11 bits long: a start bit of 0, then data bits 0 through 7, then two stop bits of 1.
- R3: After reset, `txd_o` is 1 and `ready_o` is 1.
- R4: A byte is taken only in a cycle where both `valid_i` and `ready_o` are 1. `ready_o` is 0 in the following cycle. A `valid_i` pulse while `ready_o` is 0 sends nothing.
- R5: `txd_o` changes only on the clock edge that follows a baud tick. While no frame is active, `txd_o` stays 1.
- R6: `ready_o` rises at the start of the second stop bit. A byte taken during that stop bit has its start bit immediately after it, so the start bits of back-to-back frames are exactly 11 bit periods apart.
- R7: When `inc_i` is set to round(baud × 2^20 / f_clk), the measured bit period is within ±2% of 1/baud at both 9600 and 115200 baud.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous reset, active high |
| inc_i | input | 20 | Phase increment added on every clock |
| data_i | input | 8 | Byte to send |
| valid_i | input | 1 | `data_i` holds a byte to send |
| ready_o | output | 1 | Holding register can take a byte |
| txd_o | output | 1 | Serial line output |

## Verification
The hardest case to reach is the handover between frames. The next byte must arrive in the very cycle `ready_o` rises during the second stop bit, so that the frame boundary can show whether an idle bit has slipped in. The stimulus reaches it by holding `valid_i` high with the following byte while all 256 byte values are sent back-to-back at a 16-clock bit period, and the distance between successive start edges is then checked. The fractional periods that matter at real baud rates come from increments that do not divide 2^20. These are measured over several bit edges against the target period.

// File: rtl/uart_tx_phase.sv
module uart_tx_phase #(
  parameter int ACC_W  = 20,
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [ACC_W-1:0]  inc_i,
  input  logic [DATA_W-1:0] data_i,
  input  logic              valid_i,
  output logic              ready_o,
  output logic              txd_o
);

  localparam int FRAME_W = DATA_W + 3;
  localparam int CNT_W   = $clog2(DATA_W + 2) + 1;
  localparam logic [CNT_W-1:0] CNT_TOP = CNT_W'(DATA_W + 1);

  logic [ACC_W-1:0]   acc_q;
  logic               msb_q;
  logic [CNT_W-1:0]   cnt_q;
  logic               idle_q;
  logic               pend_q;
  logic [DATA_W-1:0]  hold_q;
  logic [FRAME_W-1:0] sr_q;

  logic tick, frame_end, load, accept;

  assign tick      = acc_q[ACC_W-1] & ~msb_q;
  assign frame_end = idle_q | cnt_q[CNT_W-1];
  assign load      = tick & frame_end & pend_q;
  assign ready_o   = ~pend_q & frame_end;
  assign accept    = valid_i & ready_o;
  assign txd_o     = sr_q[0];

  always_ff @(posedge clk) begin
    if (rst) begin
      acc_q  <= '0;
      msb_q  <= 1'b0;
      cnt_q  <= '1;
      idle_q <= 1'b1;
      pend_q <= 1'b0;
      hold_q <= '0;
      sr_q   <= '1;
    end else begin
      acc_q <= acc_q + inc_i;
      msb_q <= acc_q[ACC_W-1];
      if (accept) begin
        hold_q <= data_i;
        pend_q <= 1'b1;
      end
      if (tick) begin
        if (frame_end) begin
          if (pend_q) begin
            sr_q   <= {2'b11, hold_q, 1'b0};
            cnt_q  <= CNT_TOP;
            idle_q <= 1'b0;
            pend_q <= 1'b0;
          end else begin
            idle_q <= 1'b1;
          end
        end else begin
          sr_q  <= {1'b1, sr_q[FRAME_W-1:1]};
          cnt_q <= cnt_q - CNT_W'(1);
        end
      end
    end
  end

  assert_line_hold_R5: assert property (@(posedge clk) disable iff (rst)
    !tick |=> ($stable(txd_o) && $stable(cnt_q)))
    else $error("line or count moved without a baud tick");

  assert_idle_high_R5: assert property (@(posedge clk) disable iff (rst)
    idle_q |-> txd_o)
    else $error("line low while idle");

  assert_start_bit_R2: assert property (@(posedge clk) disable iff (rst)
    load |=> (!txd_o && cnt_q == CNT_TOP))
    else $error("frame load did not put start bit on line");

  assert_ready_drop_R4: assert property (@(posedge clk) disable iff (rst)
    accept |=> !ready_o)
    else $error("ready stayed high after accept");

  assert_last_stop_R6: assert property (@(posedge clk) disable iff (rst)
    $rose(cnt_q[CNT_W-1]) |-> (ready_o && txd_o))
    else $error("final stop bit without ready or high line");

endmodule

// File: tb/uart_tx_phase_bench.sv
module uart_tx_phase_bench;
  localparam real FCLK = 125.0e6;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [19:0] inc = 20'd65536;
  logic [7:0]  data = 8'h00;
  logic        valid = 1'b0;
  logic        ready, txd;

  int  checks = 0, errors = 0, cyc = 0;
  real per = 16.0;
  bit  rx_en = 1'b1, gap_chk = 1'b0, done = 1'b0;
  int  last_fall = -1;
  logic [7:0] sent_q[$];

  uart_tx_phase u_uart_tx_phase (
    .clk(clk), .rst(rst), .inc_i(inc), .data_i(data),
    .valid_i(valid), .ready_o(ready), .txd_o(txd)
  );

  always #4 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  task automatic chk(bit ok, string tag, int act, int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual %0d expected %0d", tag, act, exp);
    end
  endtask

  task automatic do_reset();
    @(negedge clk); rst = 1'b1; valid = 1'b0;
    repeat (4) @(negedge clk);
    rst = 1'b0;
  endtask

  task automatic set_baud(real baud);
    inc = 20'($rtoi(baud * 1048576.0 / FCLK + 0.5));
    per = 1048576.0 / real'(inc);
  endtask

  task automatic send(logic [7:0] b);
    @(negedge clk); data = b; valid = 1'b1;
    while (!ready) @(negedge clk);
    @(posedge clk);
    sent_q.push_back(b);
    @(negedge clk);
    chk(!ready, "R4 ready after accept", int'(ready), 0);
  endtask

  task automatic measure(int nedges, output int span);
    logic p;
    int t0;
    p = txd;
    while (1) begin
      @(negedge clk);
      if (p && !txd) break;
      p = txd;
    end
    t0 = cyc; p = 1'b0;
    for (int e = 0; e < nedges; e++) begin
      while (1) begin
        @(negedge clk);
        if (txd != p) break;
      end
      p = txd;
    end
    span = cyc - t0;
  endtask

  task automatic rx_frame();
    int t_fall, waited, w;
    bit framing;
    logic [7:0] b;
    logic [7:0] exp;
    t_fall = cyc; waited = 0; framing = 1'b1; b = '0;
    if (gap_chk && last_fall >= 0)
      chk(t_fall - last_fall == 176, "R1 R6 start spacing", t_fall - last_fall, 176);
    last_fall = t_fall;
    for (int k = 0; k < 11; k++) begin
      w = $rtoi(per * (real'(k) + 0.5) + 0.5);
      repeat (w - waited) @(negedge clk);
      waited = w;
      if (k == 0) framing &= !txd;
      else if (k <= 8) b[k-1] = txd;
      else framing &= txd;
    end
    chk(framing, "R2 start/stop bits", int'(framing), 1);
    if (sent_q.size() == 0) begin
      chk(1'b0, "R4 unexpected frame", int'(b), -1);
    end else begin
      exp = sent_q.pop_front();
      chk(b == exp, "R2 data byte", int'(b), int'(exp));
    end
  endtask

  initial begin
    logic prev;
    prev = 1'b1;
    forever begin
      @(negedge clk);
      if (rx_en && prev && !txd) begin
        rx_frame();
        prev = 1'b1;
      end else begin
        prev = txd;
      end
    end
  end

  initial begin
    int span;
    real target;
    do_reset();
    @(negedge clk);
    chk(txd == 1'b1, "R3 line after reset", int'(txd), 1);
    chk(ready == 1'b1, "R3 ready after reset", int'(ready), 1);
    for (int i = 0; i < 100; i++) begin
      @(negedge clk);
      if (txd !== 1'b1) chk(1'b0, "R5 idle line", int'(txd), 1);
    end
    chk(txd == 1'b1, "R5 idle line held", int'(txd), 1);

    gap_chk = 1'b1; last_fall = -1;
    for (int i = 0; i < 256; i++) send(8'(i));
    @(negedge clk); valid = 1'b0;
    while (sent_q.size() != 0) @(negedge clk);
    repeat (20) @(negedge clk);
    gap_chk = 1'b0;

    send(8'h3C);
    valid = 1'b0;
    repeat (20) @(negedge clk);
    data = 8'hFF; valid = 1'b1;
    for (int i = 0; i < 30; i++) begin
      @(negedge clk);
      if (ready) chk(1'b0, "R4 ready during frame", 1, 0);
    end
    valid = 1'b0;
    repeat (250) @(negedge clk);
    chk(sent_q.size() == 0, "R4 ignored offer", sent_q.size(), 0);
    chk(ready == 1'b1, "R6 ready after frame", int'(ready), 1);
    chk(txd == 1'b1, "R5 line high after frame", int'(txd), 1);

    do_reset();
    set_baud(115200.0);
    send(8'h55);
    valid = 1'b0;
    measure(9, span);
    target = 9.0 * FCLK / 115200.0;
    chk(real'(span) >= 0.98 * target && real'(span) <= 1.02 * target,
        "R7 period 115200", span, $rtoi(target));
    send(8'hA3);
    send(8'h0F);
    @(negedge clk); valid = 1'b0;
    while (sent_q.size() != 0) @(negedge clk);
    repeat (50) @(negedge clk);

    rx_en = 1'b0;
    do_reset();
    set_baud(9600.0);
    send(8'h55);
    valid = 1'b0;
    measure(2, span);
    target = 2.0 * FCLK / 9600.0;
    chk(real'(span) >= 0.98 * target && real'(span) <= 1.02 * target,
        "R7 period 9600", span, $rtoi(target));

    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      chk(1'b0, "watchdog expired", cyc, 0);
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule